// File: doc/BRIEF.md
# Serial Banked Register Write Decoder

This block is the write path of a serial-peripheral slave. While the active-low select is held low, the host clocks in one command byte and then one data byte, most significant bit first, with input bits taken on each rising edge of the serial clock. The command byte carries a 3-bit operation code in its top bits and a 5-bit register address in its low bits. When the operation code means "write register", the data byte that follows is committed to one of 32 registers in the bank that the bank-select input names. The commit happens on the rising clock edge that carries the last data bit.

The decoder runs entirely in the serial clock domain. A high level on the select pin holds the bit counter, the shift register, the captured address and the state machine in reset, so every transaction starts clean. A transaction that ends early leaves the register array untouched. The state machine has three states. CMD collects the command byte. DATA collects the data byte and makes the commit. IGNORE discards every later bit until the select rises. The transitions are: CMD->DATA on a complete command byte with the write code; CMD->IGNORE on a complete command byte with any other code; DATA->IGNORE on the commit edge; and any state->CMD asynchronously while select is high. A 128-entry register array (4 banks of 32) keeps the committed bytes, and a combinational read port exposes them.

Top module: `spi_wcr_decoder`

## Requirements
- R1: While `rst_n` is low, every register reads 0 through `rd_data`, and `wr_stb` is low whenever `cs_n` is high.
- R2: A high level on `cs_n` asynchronously clears all partial transaction state, so a transaction that follows an aborted one decodes from its own first bit.
- R3: The physical register index is `{bank_sel, A4..A0}` (bank in bits 6:5, address in bits 4:0), with `bank_sel` sampled at the commit edge. Registers in other banks keep their values.
- R4: The write code is 3'b010, taken from command bits 7:5, and the address comes from command bits 4:0. The data byte is sent D7 first. The write takes effect on the 16th rising `sck` edge after `cs_n` falls, and `wr_stb` is high only during the cycle that ends on that edge.
- R5: Only one data byte is written per transaction. Any bits clocked after the commit, until `cs_n` rises, change no register.
- R6: A command byte whose code is not 3'b010 causes no write anywhere for the rest of that transaction.
- R7: If `cs_n` rises before the 8th data bit, no register changes.
- R8: `so_oe` stays low at all times, so the serial output remains high-impedance during the write command.
- R9: Registers can be written in any order, and each write changes only its target register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of the register array |
| sck | input | 1 | Serial clock; input bits are sampled on its rising edge |
| cs_n | input | 1 | Active-low chip select; a high level resets the decoder |
| sdi | input | 1 | Serial data in, MSb first |
| bank_sel | input | 2 | Currently selected register bank |
| so_oe | output | 1 | Serial output enable (always low for this command) |
| wr_stb | output | 1 | Commit strobe, high during the cycle that ends on the commit edge |
| wr_idx | output | 7 | Physical register index being written |
| wr_data | output | 8 | Byte being written |
| rd_idx | input | 7 | Read-port register index |
| rd_data | output | 8 | Contents of register `rd_idx` |

## Verification
On every cycle, the assertions check that the commit strobe appears only on the 16th edge of a selected transaction, that it is never raised twice in a row, that the strobe's index carries the live bank bits, and that the output enable stays off. Only the bench's scenarios can show the data path end to end: the bit order of the assembled byte, that an aborted or non-write command leaves the array alone, that bits after the commit are discarded, and that writes in arbitrary order across banks reach exactly their targets.

// File: rtl/spi_wcr_pkg.sv
package spi_wcr_pkg;

    localparam int unsigned OP_W   = 3;
    localparam int unsigned ADDR_W = 5;
    localparam int unsigned BANK_W = 2;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned CMD_W  = OP_W + ADDR_W;
    localparam int unsigned IDX_W  = BANK_W + ADDR_W;

    localparam logic [OP_W-1:0] OP_WRITE_REG = 3'b010;

    typedef enum logic [1:0] {
        ST_CMD    = 2'd0,
        ST_DATA   = 2'd1,
        ST_IGNORE = 2'd2
    } wcr_state_e;

endpackage

// File: rtl/spi_wcr_shifter.sv
module spi_wcr_shifter #(
    parameter int unsigned SH_W  = 8,
    parameter int unsigned CNT_W = 5,
    parameter int unsigned CNT_MAX = 16
) (
    input  logic             sck,
    input  logic             cs_n,
    input  logic             sdi,
    output logic [SH_W-1:0]  shreg,
    output logic [CNT_W-1:0] bitcnt
);

    // bitcnt = number of bits already taken in this transaction, saturating
    always_ff @(posedge sck or posedge cs_n) begin
        if (cs_n) begin
            shreg  <= '0;
            bitcnt <= '0;
        end else begin
            shreg <= {shreg[SH_W-2:0], sdi};
            if (bitcnt != CNT_W'(CNT_MAX)) begin
                bitcnt <= bitcnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/spi_wcr_fsm.sv
module spi_wcr_fsm
    import spi_wcr_pkg::*;
#(
    parameter int unsigned CNT_W = 5
) (
    input  logic              sck,
    input  logic              cs_n,
    input  logic              sdi,
    input  logic [CMD_W-2:0]  cmd_prev,
    input  logic [CNT_W-1:0]  bitcnt,
    output wcr_state_e        state,
    output logic [ADDR_W-1:0] addr_q,
    output logic              commit,
    output logic              so_oe
);

    localparam logic [CNT_W-1:0] LAST_CMD  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(CMD_W + DATA_W - 1);

    wcr_state_e       state_d;
    logic [CMD_W-1:0] cmd_word;
    logic             cmd_done;
    logic             data_done;

    assign cmd_word  = {cmd_prev, sdi};
    assign cmd_done  = (bitcnt == LAST_CMD);
    assign data_done = (bitcnt == LAST_DATA);

    // next-state logic
    always_comb begin
        state_d = state;
        unique case (state)
            ST_CMD: begin
                if (cmd_done) begin
                    if (cmd_word[CMD_W-1 -: OP_W] == OP_WRITE_REG) begin
                        state_d = ST_DATA;
                    end else begin
                        state_d = ST_IGNORE;
                    end
                end
            end
            ST_DATA: begin
                if (data_done) begin
                    state_d = ST_IGNORE;
                end
            end
            ST_IGNORE: begin
                state_d = ST_IGNORE;
            end
            default: begin
                state_d = ST_IGNORE;
            end
        endcase
    end

    // state register, held at CMD while select is high
    always_ff @(posedge sck or posedge cs_n) begin
        if (cs_n) begin
            state <= ST_CMD;
        end else begin
            state <= state_d;
        end
    end

    // address capture at the end of the command byte
    always_ff @(posedge sck or posedge cs_n) begin
        if (cs_n) begin
            addr_q <= '0;
        end else if (state == ST_CMD && cmd_done) begin
            addr_q <= cmd_word[ADDR_W-1:0];
        end
    end

    // outputs
    always_comb begin
        commit = 1'b0;
        so_oe  = 1'b0;
        unique case (state)
            ST_CMD:    commit = 1'b0;
            ST_DATA:   commit = data_done & ~cs_n;
            ST_IGNORE: commit = 1'b0;
            default:   commit = 1'b0;
        endcase
    end

endmodule

// File: rtl/spi_wcr_regbank.sv
module spi_wcr_regbank #(
    parameter int unsigned IDX_W  = 7,
    parameter int unsigned DATA_W = 8
) (
    input  logic              sck,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_reg
        always_ff @(posedge sck or negedge rst_n) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (we && widx == IDX_W'(g)) begin
                mem[g] <= wdata;
            end
        end
    end

    assign rdata = mem[ridx];

endmodule

// File: rtl/spi_wcr_decoder.sv
module spi_wcr_decoder
    import spi_wcr_pkg::*;
(
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              sdi,
    input  logic [BANK_W-1:0] bank_sel,
    output logic              so_oe,
    output logic              wr_stb,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    localparam int unsigned TOTAL = CMD_W + DATA_W;
    localparam int unsigned CNT_W = $clog2(TOTAL + 1);
    localparam int unsigned SH_W  = (CMD_W > DATA_W) ? CMD_W - 1 : DATA_W - 1;

    logic [SH_W-1:0]   shreg;
    logic [CNT_W-1:0]  bitcnt;
    wcr_state_e        state;
    logic [ADDR_W-1:0] addr_q;
    logic              commit;

    spi_wcr_shifter #(
        .SH_W   (SH_W),
        .CNT_W  (CNT_W),
        .CNT_MAX(TOTAL)
    ) u_shift (
        .sck   (sck),
        .cs_n  (cs_n),
        .sdi   (sdi),
        .shreg (shreg),
        .bitcnt(bitcnt)
    );

    spi_wcr_fsm #(
        .CNT_W(CNT_W)
    ) u_fsm (
        .sck     (sck),
        .cs_n    (cs_n),
        .sdi     (sdi),
        .cmd_prev(shreg[CMD_W-2:0]),
        .bitcnt  (bitcnt),
        .state   (state),
        .addr_q  (addr_q),
        .commit  (commit),
        .so_oe   (so_oe)
    );

    assign wr_stb  = commit;
    assign wr_idx  = {bank_sel, addr_q};
    assign wr_data = {shreg[DATA_W-2:0], sdi};

    spi_wcr_regbank #(
        .IDX_W (IDX_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .sck  (sck),
        .rst_n(rst_n),
        .we   (wr_stb),
        .widx (wr_idx),
        .wdata(wr_data),
        .ridx (rd_idx),
        .rdata(rd_data)
    );

endmodule

// File: rtl/spi_wcr_checker.sv
module spi_wcr_checker
    import spi_wcr_pkg::*;
(
    input logic              rst_n,
    input logic              sck,
    input logic              cs_n,
    input logic [BANK_W-1:0] bank_sel,
    input logic              so_oe,
    input logic              wr_stb,
    input logic [IDX_W-1:0]  wr_idx
);

    localparam int unsigned COMMIT_EDGE = CMD_W + DATA_W;

    // independent count of rising edges seen since select fell
    logic [5:0] edges;
    always_ff @(posedge sck or posedge cs_n) begin
        if (cs_n) begin
            edges <= '0;
        end else if (edges != 6'd63) begin
            edges <= edges + 1'b1;
        end
    end

    // R4: strobe only in the cycle that ends on the 16th edge
    p_strobe_timing_r4: assert property (@(posedge sck) disable iff (!rst_n || cs_n)
        wr_stb |-> (edges == 6'(COMMIT_EDGE - 1)));

    // R5: no strobe on two consecutive edges
    p_single_commit_r5: assert property (@(posedge sck) disable iff (!rst_n || cs_n)
        wr_stb |=> !wr_stb);

    // R3: bank bits of the index follow the bank input
    p_bank_index_r3: assert property (@(posedge sck) disable iff (!rst_n || cs_n)
        wr_stb |-> (wr_idx[IDX_W-1 -: BANK_W] == bank_sel));

    // R8: output driver never enabled
    p_out_hiz_r8: assert property (@(posedge sck) disable iff (!rst_n)
        !so_oe);

    // R1: no strobe while deselected
    always_comb begin
        if (cs_n && rst_n) begin
            p_idle_no_stb_r1: assert (!wr_stb);
        end
    end

endmodule

bind spi_wcr_decoder spi_wcr_checker u_chk (
    .rst_n   (rst_n),
    .sck     (sck),
    .cs_n    (cs_n),
    .bank_sel(bank_sel),
    .so_oe   (so_oe),
    .wr_stb  (wr_stb),
    .wr_idx  (wr_idx)
);

// File: tb/spi_wcr_decoder_tb.sv
module spi_wcr_decoder_tb;

    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       cs_n = 1'b1;
    logic       sdi = 1'b0;
    logic [1:0] bank_sel = 2'd0;
    logic       so_oe;
    logic       wr_stb;
    logic [6:0] wr_idx;
    logic [7:0] wr_data;
    logic [6:0] rd_idx = 7'd0;
    logic [7:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] model [128];

    always #10 sck = ~sck;   // 50 MHz

    spi_wcr_decoder u_dut (
        .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sdi(sdi), .bank_sel(bank_sel),
        .so_oe(so_oe), .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_reg(input string tag, input int idx);
        rd_idx = 7'(idx);
        #1;
        check(tag, 32'(rd_data), 32'(model[idx]));
    endtask

    task automatic check_all(input string tag);
        int bad = 0;
        for (int i = 0; i < 128; i++) begin
            rd_idx = 7'(i);
            #1;
            if (rd_data !== model[i]) bad++;
        end
        check(tag, 32'(bad), 32'd0);
    endtask

    // send the first nbits of a 24-bit stream MSb first, then deselect
    task automatic xfer(input logic [23:0] bits, input int nbits);
        @(negedge sck);
        cs_n = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            sdi = bits[23-i];
            @(negedge sck);
        end
        cs_n = 1'b1;
        sdi  = 1'b0;
        @(negedge sck);
    endtask

    function automatic logic [7:0] cmd(input logic [2:0] op, input logic [4:0] a);
        return {op, a};
    endfunction

    task automatic t_reset;
        for (int i = 0; i < 128; i++) model[i] = 8'h00;
        rst_n = 1'b0;
        repeat (2) @(negedge sck);
        check_all("R1 registers clear in reset");
        check("R1 strobe low when deselected", 32'(wr_stb), 32'd0);
        rst_n = 1'b1;
        @(negedge sck);
        check("R8 output enable low", 32'(so_oe), 32'd0);
    endtask

    task automatic t_basic_write;
        bank_sel = 2'd1;
        xfer({cmd(3'b010, 5'd7), 8'hA5, 8'h00}, 16);
        model[{2'd1, 5'd7}] = 8'hA5;
        check_reg("R4 basic write bank1 addr7", 39);
        check_all("R3 other registers untouched");
    endtask

    task automatic t_strobe_cycle;
        // observe strobe just before the 16th edge
        bank_sel = 2'd2;
        @(negedge sck);
        cs_n = 1'b0;
        for (int i = 0; i < 16; i++) begin
            sdi = ({cmd(3'b010, 5'd3), 8'h5C} >> (15 - i)) & 1'b1;
            #1;
            if (i == 14) check("R4 no strobe before last bit", 32'(wr_stb), 32'd0);
            if (i == 15) begin
                check("R4 strobe on last data bit", 32'(wr_stb), 32'd1);
                check("R3 strobe index", 32'(wr_idx), 32'({2'd2, 5'd3}));
                check("R4 strobe data MSb first", 32'(wr_data), 32'h5C);
                check("R8 output enable low mid-transfer", 32'(so_oe), 32'd0);
            end
            @(negedge sck);
        end
        check("R5 strobe drops after commit", 32'(wr_stb), 32'd0);
        cs_n = 1'b1;
        @(negedge sck);
        model[{2'd2, 5'd3}] = 8'h5C;
        check_reg("R4 value after commit", 67);
    endtask

    task automatic t_abort;
        bank_sel = 2'd1;
        xfer({cmd(3'b010, 5'd7), 8'h3C, 8'h00}, 15);
        check_reg("R7 abort after 7 data bits", 39);
        xfer({cmd(3'b010, 5'd7), 8'hFF, 8'h00}, 9);
        check_reg("R7 abort after 1 data bit", 39);
    endtask

    task automatic t_restart;
        bank_sel = 2'd0;
        // partial command, then a full write to a different address
        xfer({cmd(3'b010, 5'd1), 8'h00, 8'h00}, 5);
        xfer({cmd(3'b010, 5'd30), 8'h96, 8'h00}, 16);
        model[30] = 8'h96;
        check_reg("R2 fresh decode after aborted command", 30);
        check_reg("R2 stale address not written", 1);
    endtask

    task automatic t_bad_opcode;
        bank_sel = 2'd3;
        xfer({cmd(3'b011, 5'd4), 8'hEE, 8'h77}, 24);
        xfer({cmd(3'b000, 5'd4), 8'hEE, 8'h77}, 24);
        xfer({cmd(3'b110, 5'd4), 8'hEE, 8'h77}, 24);
        check_all("R6 non-write opcodes change nothing");
    endtask

    task automatic t_extra_bits;
        bank_sel = 2'd3;
        xfer({cmd(3'b010, 5'd31), 8'h81, 8'hC3}, 24);
        model[127] = 8'h81;
        check_reg("R5 first byte kept", 127);
        check_all("R5 trailing byte ignored");
    endtask

    task automatic t_any_order;
        logic [4:0] addrs [6] = '{5'd20, 5'd2, 5'd17, 5'd0, 5'd9, 5'd20};
        logic [1:0] banks [6] = '{2'd0, 2'd3, 2'd2, 2'd1, 2'd0, 2'd2};
        for (int i = 0; i < 6; i++) begin
            bank_sel = banks[i];
            xfer({cmd(3'b010, addrs[i]), 8'(8'h11 * (i + 3)), 8'h00}, 16);
            model[{banks[i], addrs[i]}] = 8'(8'h11 * (i + 3));
        end
        check_reg("R9 bank0 addr20", 20);
        check_reg("R9 bank2 addr20", 84);
        check_all("R9 scattered writes land on targets only");
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge sck);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_basic_write();
        t_strobe_cycle();
        t_abort();
        t_restart();
        t_bad_opcode();
        t_extra_bits();
        t_any_order();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule